// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Monitor

This block sits between a CAN controller's transmit line and the enable of the bus driver. It guards against a node that holds its transmit line dominant (low) because of a hardware or software failure. After a dominant-going edge the block starts a timer. If the line is still dominant when the timer expires, the block drops the driver enable and raises a fault flag. This frees the bus for the other nodes. As soon as the transmit line reads recessive again, the driver comes back and the flag clears. The receive path is not affected: received bus data passes straight through at all times, including during a fault.

The block is active only in normal mode. In standby the driver enable is held low and the timer does not run. A node that enters normal mode while its transmit line is already dominant has not produced a dominant-going edge. Its driver therefore stays off, with no fault raised, until the line has been seen recessive once.

The timeout is set by two parameters, the clock frequency in hertz and the timeout in microseconds. The cycle limit is LIMIT = (CLK_HZ/1000)·TIMEOUT_US/1000. The nominal timeout of 1200 µs lets a node send 11 dominant bits in a row, the worst case the protocol allows, down to about 9.2 kbit/s. The transmit input is resynchronised through two flops before edges are detected.

Top module: `can_dom_timeout_mon`

## Requirements
- R1: `txd_in` low means dominant. A recessive-to-dominant transition arms the timer. Let edge E be the first rising clock edge that samples `txd_in` low. If `txd_in` stays low for at least LIMIT sampling edges, `dto_fault` goes to 1 and `drv_en` goes to 0 at edge E+LIMIT+1.
- R2: If `txd_in` is low for fewer than LIMIT sampling edges, `dto_fault` stays 0 and `drv_en` stays 1.
- R3: Let edge F be the first edge that samples `txd_in` high again. At edge F+2, `dto_fault` returns to 0 and `drv_en` returns to 1. The fault lasts exactly (number of low samples − LIMIT + 1) cycles.
- R4: A return to recessive before the limit clears the count. Two dominant runs of LIMIT−1 samples each, separated by one recessive sample, raise no fault. A run of LIMIT samples after such a run times out on its own schedule (R1).
- R5: While `normal_mode` is 0, `drv_en` and `dto_fault` are 0 from the next edge on, and no dominant duration raises a fault.
- R6: On entry to normal mode with `txd_in` already low, `drv_en` and `dto_fault` stay 0 however long the low lasts. `drv_en` rises at edge F+2, where F is the first edge that samples `txd_in` high.
- R7: `rxd_out` equals `bus_rx` combinationally at all times, including while `dto_fault` is 1.
- R8: While `rst` is high, `drv_en` and `dto_fault` are 0. After reset, with `txd_in` high and `normal_mode` 1, `drv_en` is 1 from the first edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_in | input | 1 | Transmit data from the controller, low = dominant |
| normal_mode | input | 1 | 1 = normal mode, 0 = standby |
| bus_rx | input | 1 | Received bus level from the receiver |
| drv_en | output | 1 | Bus driver enable |
| dto_fault | output | 1 | Dominant timeout fault flag |
| rxd_out | output | 1 | Received data passed through to the controller |

## Verification
Two functions can act in the same cycle: the timeout firing and the release on recessive. A dominant run of exactly LIMIT samples makes the fault start on the edge just before the recessive level reaches the monitor. The bench sweeps run lengths from 1 to LIMIT+10. For each run it compares the first-fault cycle, the number of fault cycles, the number of driver-off cycles and the release cycle with values computed from LIMIT. During the faults it also toggles `bus_rx`, which shows that the receive pass-through keeps working while the transmit path is blocked.

// File: rtl/can_dom_timeout_mon.sv
module can_dom_timeout_mon #(
  parameter int CLK_HZ     = 40_000_000,
  parameter int TIMEOUT_US = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  input  logic normal_mode,
  input  logic bus_rx,
  output logic drv_en,
  output logic dto_fault,
  output logic rxd_out
);

  localparam int LIMIT = (CLK_HZ / 1000) * TIMEOUT_US / 1000;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          armed_q, hold_q;
  logic [CW-1:0] cnt_q;

  logic          tx_s, fall;
  logic          armed_d, hold_d, fault_d;
  logic [CW-1:0] cnt_d;

  assign tx_s    = sync_q[1];
  assign fall    = prev_q & ~tx_s;
  assign rxd_out = bus_rx;

  always_comb begin
    armed_d = armed_q;
    hold_d  = hold_q;
    fault_d = dto_fault;
    cnt_d   = cnt_q;
    if (!normal_mode) begin
      armed_d = 1'b0;
      hold_d  = 1'b1;
      fault_d = 1'b0;
      cnt_d   = '0;
    end else if (tx_s) begin
      armed_d = 1'b0;
      hold_d  = 1'b0;
      fault_d = 1'b0;
      cnt_d   = '0;
    end else if (fall && !hold_q) begin
      armed_d = 1'b1;
      cnt_d   = CW'(1);
      fault_d = (LIMIT == 1);
    end else if (armed_q && !dto_fault) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(LIMIT - 1)) fault_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= 2'b11;
      prev_q    <= 1'b1;
      armed_q   <= 1'b0;
      hold_q    <= 1'b1;
      cnt_q     <= '0;
      dto_fault <= 1'b0;
      drv_en    <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], txd_in};
      prev_q    <= tx_s;
      armed_q   <= armed_d;
      hold_q    <= hold_d;
      cnt_q     <= cnt_d;
      dto_fault <= fault_d;
      drv_en    <= normal_mode & ~hold_d & ~fault_d;
    end
  end

  // R1
  fault_blocks_drv_chk: assert property (@(posedge clk) disable iff (rst)
    dto_fault |-> !drv_en);

  // R2
  no_early_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dto_fault) |-> $past(cnt_q) == CW'(LIMIT - 1));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (dto_fault && tx_s && normal_mode) |=> !dto_fault);

  // R5
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    !normal_mode |=> (!drv_en && !dto_fault));

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (!drv_en && !dto_fault));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT));

endmodule

// File: tb/can_dom_timeout_mon_bench.sv
module can_dom_timeout_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int TIMEOUT_US = 20;
  localparam int LIMIT      = (CLK_HZ / 1000) * TIMEOUT_US / 1000;

  logic clk = 1'b0;
  logic rst, txd_in, normal_mode, bus_rx;
  logic drv_en, dto_fault, rxd_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_dom_timeout_mon #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) u_can_dom_timeout_mon (
    .clk(clk), .rst(rst), .txd_in(txd_in), .normal_mode(normal_mode),
    .bus_rx(bus_rx), .drv_en(drv_en), .dto_fault(dto_fault), .rxd_out(rxd_out));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive txd low for d sampling edges, then high; record fault statistics.
  task automatic burst(input int d, output int fcnt, output int dcnt,
                       output int first, output int last);
    fcnt = 0; dcnt = 0; first = 0; last = 0;
    txd_in = 1'b0;
    for (int i = 1; i <= d + 6; i++) begin
      @(negedge clk);
      bus_rx = i[0];
      #1;
      if (dto_fault) begin
        fcnt++;
        if (first == 0) first = i;
        last = i;
        check("R7 rxd_out during fault", rxd_out, bus_rx);
      end
      if (!drv_en) dcnt++;
      if (i == d) txd_in = 1'b1;
    end
  endtask

  initial begin
    int fc, dc, fi, la;
    rst = 1'b1; txd_in = 1'b1; normal_mode = 1'b1; bus_rx = 1'b1;
    idle(3);
    check("R8 drv_en in reset", drv_en, 0);
    check("R8 fault in reset", dto_fault, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 drv_en after reset", drv_en, 1);
    check("R8 fault after reset", dto_fault, 0);
    bus_rx = 1'b0; #1;
    check("R7 rxd_out low", rxd_out, 0);
    bus_rx = 1'b1; #1;
    check("R7 rxd_out high", rxd_out, 1);
    idle(2);

    for (int d = 1; d <= LIMIT + 10; d++) begin
      burst(d, fc, dc, fi, la);
      if (d >= LIMIT) begin
        check("R1 fault cycles", fc, d - LIMIT + 1);
        check("R1 driver off cycles", dc, d - LIMIT + 1);
        check("R1 onset index", fi, LIMIT + 2);
        check("R3 release index", la + 1, d + 3);
      end else begin
        check("R2 no fault", fc, 0);
        check("R2 driver stays on", dc, 0);
      end
      idle(4);
    end

    // R4: restart from zero after a short recessive gap
    burst(LIMIT - 1, fc, dc, fi, la);
    check("R4 first short run", fc, 0);
    burst(LIMIT - 1, fc, dc, fi, la);
    check("R4 second short run", fc, 0);
    check("R4 driver stays on", dc, 0);
    burst(LIMIT - 1, fc, dc, fi, la);
    burst(LIMIT, fc, dc, fi, la);
    check("R4 full run after gap faults", fc, 1);
    check("R4 full run onset", fi, LIMIT + 2);
    idle(4);

    // R5: standby
    normal_mode = 1'b0;
    @(negedge clk);
    check("R5 drv_en off in standby", drv_en, 0);
    burst(3 * LIMIT, fc, dc, fi, la);
    check("R5 no fault in standby", fc, 0);
    check("R5 driver off throughout", dc, 3 * LIMIT + 6);

    // R6: enter normal while dominant
    txd_in = 1'b0;
    idle(3);
    normal_mode = 1'b1;
    fc = 0; dc = 0;
    for (int i = 0; i < 3 * LIMIT; i++) begin
      @(negedge clk);
      if (dto_fault) fc++;
      if (!drv_en) dc++;
    end
    check("R6 no fault while held", fc, 0);
    check("R6 driver off while held", dc, 3 * LIMIT);
    txd_in = 1'b1;
    @(negedge clk); check("R6 driver index1", drv_en, 0);
    @(negedge clk); check("R6 driver index2", drv_en, 0);
    @(negedge clk); check("R6 driver index3", drv_en, 1);
    idle(2);

    // R5: fault cleared by standby
    burst(LIMIT + 8, fc, dc, fi, la);
    txd_in = 1'b0;
    idle(LIMIT + 4);
    check("R1 fault before standby", dto_fault, 1);
    normal_mode = 1'b0;
    @(negedge clk);
    check("R5 fault cleared by standby", dto_fault, 0);
    check("R5 driver off by standby", drv_en, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule